// File: doc/BRIEF.md
# In-Order Load/Store Queue

This block buffers the memory instructions of an out-of-order core in program order. The issue stage hands it a load or a store, and the queue claims the slot at its tail for it. The cycle after acceptance is the dependency phase. In that cycle the register file reports whether the base operand and the store-data operand are available, with their values or producer tags. A result broadcast that arrives in that same cycle is used as a bypass.

After the dependency phase, a slot waits for its missing operands. It captures each one from the result broadcast bus when the tag matches. The effective address is the base operand plus the sign-extended immediate, and it is formed as soon as the base is known. Only the oldest slot, at the head, may raise a memory request, so memory sees accesses strictly in program order. The head moves on when the memory side signals completion.

The free-slot count is an output every cycle, so that the scheduler can stall issue. A flush empties the whole queue.

Each slot runs a four-state machine:
- EMPTY goes to RESOLVE on allocate.
- RESOLVE goes to WAIT on fill, which is the dependency phase.
- WAIT goes to ISSUED on head issue.
- ISSUED goes back to EMPTY on completion.
- Flush returns any state to EMPTY.

Top module: `mem_order_queue`

## Requirements
- R1: After reset, `free_cnt` is 32 and `mem_req` is 0.
- R2: An instruction is accepted only when `iss_valid` is 1, `iss_kind` is 1 and `free_cnt` is non-zero. With `iss_kind` at 0, the queue is unchanged.
- R3: `free_cnt` falls by one on each acceptance and rises by one on each completion. When it is 0, further instructions are refused.
- R4: An accepted instruction takes its operand availability, values and tags from the `rf_*` inputs in the cycle after acceptance. A load needs only the base operand.
- R5: In that dependency cycle, an operand not ready in the register file is still taken as ready when `bc_valid` is 1 and `bc_tag` equals its `rf_*_tag`. The value is then `bc_val`.
- R6: A waiting slot captures `bc_val` for each pending operand whose tag equals `bc_tag` while `bc_valid` is 1.
- R7: `mem_addr` equals the base operand plus `iss_imm` sign-extended from bit 11.
- R8: `mem_req` is 1 only for the head slot, and only once all its operands are ready. It lasts one cycle, with `mem_store`, `mem_addr`, `mem_wdata` (the store data) and `mem_rob` describing that slot. A ready younger slot waits behind an unready head.
- R9: A `mem_done` pulse retires the head only after the head has raised its request. At any other time `mem_done` has no effect.
- R10: `flush` empties every slot, returns both pointers to slot 0 and `free_cnt` to 32, and cancels a pending dependency phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Empty the queue |
| iss_valid | input | 1 | Issue strobe |
| iss_kind | input | 1 | 1 = memory instruction for this queue |
| iss_store | input | 1 | 1 = store, 0 = load |
| iss_imm | input | 12 | Address offset, signed |
| iss_rob | input | 5 | Reorder-buffer tag of the instruction |
| rf_base_ready | input | 1 | Base operand available in the register file |
| rf_base_tag | input | 5 | Producer tag of the base when not available |
| rf_base_val | input | 32 | Base value when available |
| rf_data_ready | input | 1 | Store data available in the register file |
| rf_data_tag | input | 5 | Producer tag of the store data |
| rf_data_val | input | 32 | Store data value |
| bc_valid | input | 1 | Result broadcast valid |
| bc_tag | input | 5 | Tag of the broadcast result |
| bc_val | input | 32 | Broadcast result value |
| mem_done | input | 1 | Head memory access finished |
| mem_req | output | 1 | Head request strobe |
| mem_store | output | 1 | Request is a store |
| mem_addr | output | 32 | Effective address |
| mem_wdata | output | 32 | Store data |
| mem_rob | output | 5 | Reorder-buffer tag of the request |
| free_cnt | output | 6 | Number of free slots |

## Verification
The properties assume the following about the inputs:
- The scheduler never offers an instruction while `free_cnt` is 0 with the expectation that it is taken.
- The `rf_*` inputs are meaningful only in the cycle after an acceptance.
- `mem_done` refers to the request most recently raised.

The directed tasks follow this. They drive register-file data only in dependency cycles, and they pulse `mem_done` only after the request strobe has dropped. The only exceptions are the deliberate stray completion and the refused 33rd issue, whose effect on `free_cnt` and on the later request order is observed at the ports.

// File: rtl/mq_pkg.sv
package mq_pkg;
    typedef enum logic [1:0] {
        SLOT_EMPTY   = 2'd0,
        SLOT_RESOLVE = 2'd1,
        SLOT_WAIT    = 2'd2,
        SLOT_ISSUED  = 2'd3
    } slot_state_t;
endpackage

// File: rtl/mq_track.sv
module mq_track #(
    parameter int DEPTH = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic             pop,
    output logic [PTR_W-1:0] head_q,
    output logic [PTR_W-1:0] tail_q,
    output logic [CNT_W-1:0] free_q,
    output logic             acc_q,
    output logic [PTR_W-1:0] acc_idx_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q    <= '0;
            tail_q    <= '0;
            free_q    <= CNT_W'(DEPTH);
            acc_q     <= 1'b0;
            acc_idx_q <= '0;
        end else if (flush) begin
            head_q    <= '0;
            tail_q    <= '0;
            free_q    <= CNT_W'(DEPTH);
            acc_q     <= 1'b0;
            acc_idx_q <= '0;
        end else begin
            acc_q <= push;
            if (push) begin
                tail_q    <= tail_q + 1'b1;
                acc_idx_q <= tail_q;
            end
            if (pop) head_q <= head_q + 1'b1;
            free_q <= free_q - CNT_W'(push) + CNT_W'(pop);
        end
    end

    // R3: free count never exceeds capacity
    p_free_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        free_q <= CNT_W'(DEPTH));
    // R3: pointer distance matches occupancy
    p_occupancy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        PTR_W'(tail_q - head_q) == PTR_W'(CNT_W'(DEPTH) - free_q));
    // R10: flush restores the empty queue
    p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (free_q == CNT_W'(DEPTH) && head_q == '0 && tail_q == '0 && !acc_q));
endmodule

// File: rtl/mq_slot.sv
module mq_slot
    import mq_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int TAG_W = 5,
    parameter int IMM_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             alloc,
    input  logic             alloc_store,
    input  logic [IMM_W-1:0] alloc_imm,
    input  logic [TAG_W-1:0] alloc_rob,
    input  logic             fill,
    input  logic             rf_base_ready,
    input  logic [TAG_W-1:0] rf_base_tag,
    input  logic [XLEN-1:0]  rf_base_val,
    input  logic             rf_data_ready,
    input  logic [TAG_W-1:0] rf_data_tag,
    input  logic [XLEN-1:0]  rf_data_val,
    input  logic             bc_valid,
    input  logic [TAG_W-1:0] bc_tag,
    input  logic [XLEN-1:0]  bc_val,
    input  logic             issue,
    input  logic             done,
    output slot_state_t      st_q,
    output logic             rdy,
    output logic [XLEN-1:0]  addr_q,
    output logic [XLEN-1:0]  wdata_q,
    output logic             store_q,
    output logic [TAG_W-1:0] rob_q
);
    slot_state_t      st_d;
    logic [XLEN-1:0]  imm_q;
    logic [TAG_W-1:0] qb_q, qd_q;
    logic             rb_q, rd_q;

    // operand resolution during the dependency cycle
    logic            fb_ok, fd_ok;
    logic [XLEN-1:0] fb_val, fd_val;
    logic            wb_hit, wd_hit;

    always_comb begin
        fb_ok  = rf_base_ready || (bc_valid && bc_tag == rf_base_tag);
        fb_val = rf_base_ready ? rf_base_val : bc_val;
        fd_ok  = !store_q || rf_data_ready || (bc_valid && bc_tag == rf_data_tag);
        fd_val = rf_data_ready ? rf_data_val : bc_val;
        wb_hit = !rb_q && bc_valid && bc_tag == qb_q;
        wd_hit = !rd_q && bc_valid && bc_tag == qd_q;
    end

    // next-state process
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SLOT_EMPTY:   if (alloc) st_d = SLOT_RESOLVE;
            SLOT_RESOLVE: if (fill)  st_d = SLOT_WAIT;
            SLOT_WAIT:    if (issue) st_d = SLOT_ISSUED;
            SLOT_ISSUED:  if (done)  st_d = SLOT_EMPTY;
        endcase
        if (flush) st_d = SLOT_EMPTY;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SLOT_EMPTY;
        else        st_q <= st_d;
    end

    // payload registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            imm_q <= '0; addr_q <= '0; wdata_q <= '0; store_q <= 1'b0;
            rob_q <= '0; qb_q <= '0; qd_q <= '0; rb_q <= 1'b0; rd_q <= 1'b0;
        end else if (st_q == SLOT_EMPTY && alloc) begin
            store_q <= alloc_store;
            imm_q   <= {{(XLEN-IMM_W){alloc_imm[IMM_W-1]}}, alloc_imm};
            rob_q   <= alloc_rob;
            rb_q    <= 1'b0;
            rd_q    <= 1'b0;
        end else if (st_q == SLOT_RESOLVE && fill) begin
            rb_q <= fb_ok;
            qb_q <= rf_base_tag;
            if (fb_ok) addr_q <= fb_val + imm_q;
            rd_q <= fd_ok;
            qd_q <= rf_data_tag;
            if (fd_ok) wdata_q <= fd_val;
        end else if (st_q == SLOT_WAIT) begin
            if (wb_hit) begin
                rb_q   <= 1'b1;
                addr_q <= bc_val + imm_q;
            end
            if (wd_hit) begin
                rd_q    <= 1'b1;
                wdata_q <= bc_val;
            end
        end
    end

    // output process
    always_comb rdy = (st_q == SLOT_WAIT) && rb_q && rd_q;

    // R4: allocation is followed by the dependency phase
    p_alloc_resolve_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SLOT_EMPTY && alloc && !flush) |=> st_q == SLOT_RESOLVE);
    // R4: the dependency phase lasts exactly one cycle
    p_resolve_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SLOT_RESOLVE && !flush) |=> st_q == SLOT_WAIT);
    // R6: a matching broadcast forms the address from its value
    p_wake_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SLOT_WAIT && wb_hit && !issue && !flush) |=> (rb_q && addr_q == $past(bc_val) + imm_q));
    // R8: issue only from a ready slot
    p_issue_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> rdy);
endmodule

// File: rtl/mem_order_queue.sv
module mem_order_queue
    import mq_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int XLEN  = 32,
    parameter int TAG_W = 5,
    parameter int IMM_W = 12,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             iss_valid,
    input  logic             iss_kind,
    input  logic             iss_store,
    input  logic [IMM_W-1:0] iss_imm,
    input  logic [TAG_W-1:0] iss_rob,
    input  logic             rf_base_ready,
    input  logic [TAG_W-1:0] rf_base_tag,
    input  logic [XLEN-1:0]  rf_base_val,
    input  logic             rf_data_ready,
    input  logic [TAG_W-1:0] rf_data_tag,
    input  logic [XLEN-1:0]  rf_data_val,
    input  logic             bc_valid,
    input  logic [TAG_W-1:0] bc_tag,
    input  logic [XLEN-1:0]  bc_val,
    input  logic             mem_done,
    output logic             mem_req,
    output logic             mem_store,
    output logic [XLEN-1:0]  mem_addr,
    output logic [XLEN-1:0]  mem_wdata,
    output logic [TAG_W-1:0] mem_rob,
    output logic [CNT_W-1:0] free_cnt
);
    logic [PTR_W-1:0] head_q, tail_q, acc_idx_q;
    logic [CNT_W-1:0] free_q;
    logic             acc_q, accept, retire;

    slot_state_t      s_st    [DEPTH];
    logic [XLEN-1:0]  s_addr  [DEPTH];
    logic [XLEN-1:0]  s_wdata [DEPTH];
    logic [TAG_W-1:0] s_rob   [DEPTH];
    logic [DEPTH-1:0] s_rdy, s_store;

    always_comb begin
        accept = iss_valid && iss_kind && (free_q != '0) && !flush;
        retire = mem_done && (s_st[head_q] == SLOT_ISSUED) && !flush;
    end

    mq_track #(.DEPTH(DEPTH)) u_track (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push(accept), .pop(retire),
        .head_q(head_q), .tail_q(tail_q), .free_q(free_q),
        .acc_q(acc_q), .acc_idx_q(acc_idx_q)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        mq_slot #(.XLEN(XLEN), .TAG_W(TAG_W), .IMM_W(IMM_W)) u_slot (
            .clk(clk), .rst_n(rst_n), .flush(flush),
            .alloc(accept && tail_q == PTR_W'(i)),
            .alloc_store(iss_store), .alloc_imm(iss_imm), .alloc_rob(iss_rob),
            .fill(acc_q && acc_idx_q == PTR_W'(i)),
            .rf_base_ready(rf_base_ready), .rf_base_tag(rf_base_tag), .rf_base_val(rf_base_val),
            .rf_data_ready(rf_data_ready), .rf_data_tag(rf_data_tag), .rf_data_val(rf_data_val),
            .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
            .issue(head_q == PTR_W'(i) && s_rdy[i] && !flush),
            .done(head_q == PTR_W'(i) && mem_done),
            .st_q(s_st[i]), .rdy(s_rdy[i]), .addr_q(s_addr[i]), .wdata_q(s_wdata[i]),
            .store_q(s_store[i]), .rob_q(s_rob[i])
        );
    end

    always_comb begin
        mem_req   = s_rdy[head_q];
        mem_store = s_store[head_q];
        mem_addr  = s_addr[head_q];
        mem_wdata = s_wdata[head_q];
        mem_rob   = s_rob[head_q];
        free_cnt  = free_q;
    end

    // R8: a request is a single-cycle strobe
    p_req_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    // R9: a completion with nothing in flight leaves the count alone
    p_stray_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_done && s_st[head_q] != SLOT_ISSUED && !accept && !flush) |=> $stable(free_cnt));
    // R2: a non-memory issue does not consume a slot
    p_kind_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_kind && !retire && !flush) |=> $stable(free_cnt));
endmodule

// File: tb/mem_order_queue_test.sv
module mem_order_queue_test;
    logic        clk = 1'b0;
    logic        rst_n, flush, iss_valid, iss_kind, iss_store;
    logic [11:0] iss_imm;
    logic [4:0]  iss_rob, rf_base_tag, rf_data_tag, bc_tag, mem_rob;
    logic        rf_base_ready, rf_data_ready, bc_valid, mem_done;
    logic [31:0] rf_base_val, rf_data_val, bc_val, mem_addr, mem_wdata;
    logic        mem_req, mem_store;
    logic [5:0]  free_cnt;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    mem_order_queue uut (.*);

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle();
        flush = 0; iss_valid = 0; iss_kind = 0; iss_store = 0; iss_imm = '0; iss_rob = '0;
        rf_base_ready = 0; rf_base_tag = '0; rf_base_val = '0;
        rf_data_ready = 0; rf_data_tag = '0; rf_data_val = '0;
        bc_valid = 0; bc_tag = '0; bc_val = '0; mem_done = 0;
    endtask

    task automatic offer(input logic st, input logic [11:0] imm, input logic [4:0] rob);
        iss_valid = 1; iss_kind = 1; iss_store = st; iss_imm = imm; iss_rob = rob;
    endtask

    task automatic t_reset();
        idle(); rst_n = 0;
        tick(); tick();
        rst_n = 1;
        tick();
        chk("R1 free after reset", 32'(free_cnt), 32);
        chk("R1 no request after reset", 32'(mem_req), 0);
    endtask

    task automatic t_load_basic();
        offer(0, 12'hFFC, 5'd5); tick();
        idle(); rf_base_ready = 1; rf_base_val = 32'h1000;
        chk("R3 free after accept", 32'(free_cnt), 31);
        tick(); idle();
        chk("R4 request after fill", 32'(mem_req), 1);
        chk("R7 address with negative offset", mem_addr, 32'h0FFC);
        chk("R8 request tag", 32'(mem_rob), 5);
        chk("R8 load kind", 32'(mem_store), 0);
        tick();
        chk("R8 request is one pulse", 32'(mem_req), 0);
        mem_done = 1; tick(); idle();
        chk("R9 free after completion", 32'(free_cnt), 32);
    endtask

    task automatic t_ignore_kind();
        iss_valid = 1; iss_kind = 0; iss_rob = 5'd4; tick(); idle();
        chk("R2 kind 0 leaves free count", 32'(free_cnt), 32);
        tick();
        chk("R2 kind 0 raises no request", 32'(mem_req), 0);
    endtask

    task automatic t_order_wakeup();
        offer(0, 12'h010, 5'd1); tick();
        offer(1, 12'h008, 5'd2); rf_base_ready = 0; rf_base_tag = 5'd7; tick();
        idle(); rf_base_ready = 1; rf_base_val = 32'h200; rf_data_ready = 1; rf_data_val = 32'hAB; tick();
        idle();
        chk("R8 ready younger waits behind head", 32'(mem_req), 0);
        chk("R3 two entries held", 32'(free_cnt), 30);
        bc_valid = 1; bc_tag = 5'd7; bc_val = 32'h300; tick(); idle();
        chk("R6 wakeup raises head request", 32'(mem_req), 1);
        chk("R6 address from broadcast", mem_addr, 32'h310);
        chk("R8 head tag", 32'(mem_rob), 1);
        tick();
        mem_done = 1; tick(); idle();
        chk("R8 next entry requests", 32'(mem_req), 1);
        chk("R8 store kind", 32'(mem_store), 1);
        chk("R7 store address", mem_addr, 32'h208);
        chk("R4 store data", mem_wdata, 32'hAB);
        chk("R8 store tag", 32'(mem_rob), 2);
        tick();
        mem_done = 1; tick(); idle();
        chk("R3 queue drained", 32'(free_cnt), 32);
    endtask

    task automatic t_bypass();
        offer(0, 12'h004, 5'd3); tick();
        idle(); rf_base_ready = 0; rf_base_tag = 5'd9; bc_valid = 1; bc_tag = 5'd9; bc_val = 32'h40; tick();
        idle();
        chk("R5 bypass makes entry ready", 32'(mem_req), 1);
        chk("R5 bypass address", mem_addr, 32'h44);
        tick(); mem_done = 1; tick(); idle();
        chk("R9 retire after bypass", 32'(free_cnt), 32);
    endtask

    task automatic t_stray_done();
        offer(0, 12'h000, 5'd6); tick();
        idle(); rf_base_tag = 5'd11; tick();
        idle(); mem_done = 1; tick(); idle();
        chk("R9 stray completion ignored", 32'(free_cnt), 31);
        bc_valid = 1; bc_tag = 5'd11; bc_val = 32'h500; tick(); idle();
        chk("R9 head kept after stray completion", 32'(mem_req), 1);
        chk("R9 head tag kept", 32'(mem_rob), 6);
        chk("R6 address after late base", mem_addr, 32'h500);
        tick(); mem_done = 1; tick(); idle();
        chk("R9 retire after real request", 32'(free_cnt), 32);
    endtask

    task automatic t_full_flush();
        for (int i = 0; i < 33; i++) begin
            offer(0, 12'h000, 5'(i)); rf_base_ready = 0; rf_base_tag = 5'd20; tick();
        end
        idle(); rf_base_tag = 5'd20; tick(); idle();
        chk("R3 full queue refuses extra", 32'(free_cnt), 0);
        chk("R8 blocked head no request", 32'(mem_req), 0);
        flush = 1; tick(); idle();
        chk("R10 flush restores free count", 32'(free_cnt), 32);
        bc_valid = 1; bc_tag = 5'd20; bc_val = 32'h1; tick(); idle();
        chk("R10 flushed entries do not wake", 32'(mem_req), 0);
        offer(0, 12'h007, 5'd9); tick();
        idle(); rf_base_ready = 1; rf_base_val = 32'h100; tick(); idle();
        chk("R10 request after flush", 32'(mem_req), 1);
        chk("R10 address after flush", mem_addr, 32'h107);
        chk("R10 tag after flush", 32'(mem_rob), 9);
        tick(); mem_done = 1; tick(); idle();
        chk("R10 queue empty again", 32'(free_cnt), 32);
    endtask

    initial begin
        t_reset();
        t_load_basic();
        t_ignore_kind();
        t_order_wakeup();
        t_bypass();
        t_stray_done();
        t_full_flush();
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule